// File: doc/BRIEF.md
# LED Control Register Write Target

This block is a two-wire serial bus target that sits in front of a small LED-driver control register file. It brings the clock and data lines into the system clock domain, recognises bus start and stop conditions, and answers one of two 7-bit device addresses. A strap input picks which one. A write carries a register index followed by one data byte. A read returns the register named by the last accepted index. The target pulls the data line low through an output-enable and never drives it high.

There are four control registers. One is a general-purpose control byte. The other three set the brightness of three LED banks. Two of the banks use a 5-bit level and the third uses a 2-bit level. All four registers are always visible on parallel outputs. Bits outside a register's field always read 1.

An active-low hardware reset pin returns every register to its default value. While the pin is low, the target also stays silent on the bus.

Top module: `led_ctrl_i2c_target`

## Requirements
- R1: After reset the outputs are general control 0x20, bank A 0xE0, bank B 0xE0, bank C 0xFC, and `sda_oe` is 0.
- R2: The device address is 7'h36 when `addr_sel` is 0 and 7'h38 when it is 1. Bit 0 of the address byte is the direction bit, where 0 means write and 1 means read. A matching address byte is acknowledged by pulling SDA low during the ninth clock.
- R3: An address byte that does not match is not acknowledged. The target then ignores the bus, and changes no register, until the next START.
- R4: A write is an address byte, then an index byte, then a data byte. All three are acknowledged. The data lands in the register selected by the index: 8'h10 is general control, 8'hA0 is bank A, 8'hB0 is bank B, and 8'hC0 is bank C.
- R5: An index byte other than the four valid values is not acknowledged, and no register changes.
- R6: Bits [7:5] of banks A and B and bits [7:2] of bank C always read 1 and ignore written values. All 8 bits of general control are writable.
- R7: Only one data byte is accepted per index. Further bytes are not acknowledged and not written.
- R8: A repeated START in the middle of a transfer abandons it. The next byte is then treated as an address byte.
- R9: After a STOP, bytes clocked without a new START are ignored.
- R10: A read sends the register selected by the most recent valid index, MSB first. The target sends the same register again after a controller ACK, and releases SDA after a controller NACK.
- R11: While `hw_rst_n` is low, every register holds its default value, SDA is released, and bus traffic is ignored.
- R12: The target only begins pulling SDA low while the synchronised SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low system reset |
| hw_rst_n | input | 1 | Active-low hardware reset pin, synchronised internally |
| addr_sel | input | 1 | Address strap: 0 selects 7'h36, 1 selects 7'h38 |
| scl_i | input | 1 | Bus clock line as seen on the pad |
| sda_i | input | 1 | Bus data line as seen on the pad |
| sda_oe | output | 1 | 1 pulls SDA low (open-drain) |
| gp_ctrl | output | 8 | General control register |
| bank_a_lvl | output | 8 | Bank A brightness register |
| bank_b_lvl | output | 8 | Bank B brightness register |
| bank_c_lvl | output | 8 | Bank C brightness register |

## Verification
Two events can land on the same synchronised sample. One is a register write decided at the end of a data byte. The other is a bus condition: a repeated START, or the hardware reset pin dropping.

The bench provokes the first case by issuing a repeated START straight after an index byte has been acknowledged. It provokes the second by lowering the reset pin while a write address is on the bus. A scoreboard compares every observed 9-bit frame (the byte plus the acknowledge level) against the expected frame. Register checks at the outputs then confirm that only the intended write took effect.

// File: rtl/led_i2c_pkg.sv
// Package: shared constants, phase encoding and register-map helpers for
// the LED control bus target. Assumes exactly four control slots.
package led_i2c_pkg;
    localparam int NUM_REGS = 4;
    localparam int SLOT_W   = 2;
    localparam int BYTE_W   = 8;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_ADDR,
        PH_INDEX,
        PH_WDATA,
        PH_RDATA,
        PH_SKIP
    } phase_e;

    // Default (reset) value of a slot.
    function automatic logic [BYTE_W-1:0] slot_default(input int s);
        case (s)
            0:       return 8'h20;
            1, 2:    return 8'hE0;
            default: return 8'hFC;
        endcase
    endfunction

    // Writable bits of a slot; the other bits are held at 1.
    function automatic logic [BYTE_W-1:0] slot_mask(input int s);
        case (s)
            0:       return 8'hFF;
            1, 2:    return 8'h1F;
            default: return 8'h03;
        endcase
    endfunction

    // Index byte to {valid, slot}.
    function automatic logic [SLOT_W:0] index_lookup(input logic [BYTE_W-1:0] idx);
        case (idx)
            8'h10:   return {1'b1, 2'd0};
            8'hA0:   return {1'b1, 2'd1};
            8'hB0:   return {1'b1, 2'd2};
            8'hC0:   return {1'b1, 2'd3};
            default: return {1'b0, 2'd0};
        endcase
    endfunction
endpackage

// File: rtl/i2c_line_sync.sv
// Synchroniser plus edge detector for W bus lines. Each line passes through
// STAGES flops, then one more flop gives edge pulses. Assumes the lines
// idle high and move slowly compared with clk.
module i2c_line_sync #(
    parameter int   W       = 2,
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] lvl,
    output logic [W-1:0] rise,
    output logic [W-1:0] fall
);
    generate
        for (genvar i = 0; i < W; i++) begin : g_line
            logic [STAGES-1:0] pipe;
            logic              prev;

            // Shift the raw line in and keep the previous synchronised value.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    pipe <= {STAGES{RST_VAL}};
                    prev <= RST_VAL;
                end else begin
                    pipe <= {pipe[STAGES-2:0], din[i]};
                    prev <= pipe[STAGES-1];
                end
            end

            assign lvl[i]  = pipe[STAGES-1];
            assign rise[i] = pipe[STAGES-1] & ~prev;
            assign fall[i] = ~pipe[STAGES-1] & prev;
        end
    endgenerate
endmodule

// File: rtl/i2c_byte_engine.sv
// Bus protocol engine. It walks the address, index, write-data and read-data
// phases, counts bits on synchronised SCL edges, decides each acknowledge,
// and drives SDA low through sda_oe only while SCL is low. Assumes the bus
// condition and edge pulses come from i2c_line_sync.
module i2c_byte_engine
    import led_i2c_pkg::*;
#(
    parameter logic [6:0] ADDR_LO = 7'h36,
    parameter logic [6:0] ADDR_HI = 7'h38
) (
    input  logic              clk,
    input  logic              rst_ok,
    input  logic              addr_sel,
    input  logic              scl_lvl,
    input  logic              sda_lvl,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              bus_start,
    input  logic              bus_stop,
    input  logic [BYTE_W-1:0] rd_data,
    output logic [SLOT_W-1:0] slot_ptr,
    output logic              wr_en,
    output logic [BYTE_W-1:0] wr_data,
    output logic              sda_oe
);
    localparam logic [3:0] ACK_BIT = 4'd8;
    localparam logic [3:0] END_BIT = 4'd9;

    phase_e            phase;
    phase_e            dec_next;
    logic [3:0]        bitcnt;
    logic [BYTE_W-1:0] shreg;
    logic [BYTE_W-1:0] tx;
    logic              master_ack;
    logic              dec_ack;
    logic [SLOT_W:0]   lookup;
    logic [6:0]        dev_addr;

    assign dev_addr = addr_sel ? ADDR_HI : ADDR_LO;
    assign lookup   = index_lookup(shreg);

    // Decide the acknowledge and the next phase for a completed byte.
    always_comb begin
        dec_ack  = 1'b0;
        dec_next = PH_SKIP;
        if (phase == PH_ADDR) begin
            if (shreg[7:1] == dev_addr) begin
                dec_ack  = 1'b1;
                dec_next = shreg[0] ? PH_RDATA : PH_INDEX;
            end
        end else if (phase == PH_INDEX) begin
            if (lookup[SLOT_W]) begin
                dec_ack  = 1'b1;
                dec_next = PH_WDATA;
            end
        end else if (phase == PH_WDATA) begin
            dec_ack = 1'b1;
        end
    end

    // Phase, bit counting, shifting, acknowledge and SDA drive.
    always_ff @(posedge clk) begin
        if (!rst_ok) begin
            phase      <= PH_IDLE;
            bitcnt     <= '0;
            shreg      <= '0;
            tx         <= '0;
            master_ack <= 1'b0;
            slot_ptr   <= '0;
            wr_en      <= 1'b0;
            wr_data    <= '0;
            sda_oe     <= 1'b0;
        end else begin
            wr_en <= 1'b0;
            if (bus_start) begin
                phase  <= PH_ADDR;
                bitcnt <= '0;
                sda_oe <= 1'b0;
            end else if (bus_stop) begin
                phase  <= PH_IDLE;
                bitcnt <= '0;
                sda_oe <= 1'b0;
            end else if (phase != PH_IDLE) begin
                if (scl_rise) begin
                    if (bitcnt < ACK_BIT && phase != PH_RDATA)
                        shreg <= {shreg[BYTE_W-2:0], sda_lvl};
                    if (bitcnt == ACK_BIT && phase == PH_RDATA)
                        master_ack <= ~sda_lvl;
                    if (bitcnt != END_BIT)
                        bitcnt <= bitcnt + 4'd1;
                end else if (scl_fall) begin
                    if (bitcnt == ACK_BIT) begin
                        if (phase == PH_RDATA) begin
                            sda_oe <= 1'b0;
                        end else begin
                            sda_oe <= dec_ack;
                            if (phase == PH_INDEX && lookup[SLOT_W])
                                slot_ptr <= lookup[SLOT_W-1:0];
                            if (phase == PH_WDATA) begin
                                wr_en   <= 1'b1;
                                wr_data <= shreg;
                            end
                        end
                    end else if (bitcnt == END_BIT) begin
                        bitcnt <= '0;
                        if (phase == PH_RDATA) begin
                            if (master_ack) sda_oe <= ~tx[7];
                            else            phase  <= PH_SKIP;
                        end else if (sda_oe && dec_next == PH_RDATA) begin
                            phase  <= PH_RDATA;
                            tx     <= rd_data;
                            sda_oe <= ~rd_data[7];
                        end else begin
                            phase  <= sda_oe ? dec_next : PH_SKIP;
                            sda_oe <= 1'b0;
                        end
                    end else if (phase == PH_RDATA && bitcnt != 4'd0) begin
                        sda_oe <= ~tx[3'd7 - bitcnt[2:0]];
                    end
                end
            end
        end
    end

    assert_drive_when_low_R12: assert property (@(posedge clk) disable iff (!rst_ok)
        $rose(sda_oe) |-> !scl_lvl)
        else $error("R12: SDA pulled low while SCL high");

    assert_start_restarts_R8: assert property (@(posedge clk) disable iff (!rst_ok)
        bus_start |=> (phase == PH_ADDR && bitcnt == 4'd0 && !sda_oe))
        else $error("R8: START did not restart the address phase");

    assert_skip_no_write_R7: assert property (@(posedge clk) disable iff (!rst_ok)
        (phase == PH_SKIP) |-> !wr_en)
        else $error("R7: write strobe while ignoring the bus");
endmodule

// File: rtl/led_reg_file.sv
// Four control registers. Each has a per-slot default and a writable mask,
// and the bits outside the mask are held at 1. A single write port is
// addressed by slot, and a read mux serves the same slot.
module led_reg_file
    import led_i2c_pkg::*;
(
    input  logic                            clk,
    input  logic                            rst_ok,
    input  logic                            wr_en,
    input  logic [SLOT_W-1:0]               slot,
    input  logic [BYTE_W-1:0]               wr_data,
    output logic [NUM_REGS-1:0][BYTE_W-1:0] regs_q,
    output logic [BYTE_W-1:0]               rd_data
);
    generate
        for (genvar s = 0; s < NUM_REGS; s++) begin : g_slot
            localparam logic [BYTE_W-1:0] DEF  = slot_default(s);
            localparam logic [BYTE_W-1:0] MASK = slot_mask(s);

            // Load default on reset; otherwise take masked write data.
            always_ff @(posedge clk) begin
                if (!rst_ok)
                    regs_q[s] <= DEF;
                else if (wr_en && slot == SLOT_W'(s))
                    regs_q[s] <= (wr_data & MASK) | ~MASK;
            end

            assert_unused_ones_R6: assert property (@(posedge clk) disable iff (!rst_ok)
                (regs_q[s] & ~MASK) == ~MASK)
                else $error("R6: unused bit not 1 in slot %0d", s);

            assert_hold_without_write_R5: assert property (@(posedge clk) disable iff (!rst_ok)
                ($past(rst_ok) && !$past(wr_en)) |-> $stable(regs_q[s]))
                else $error("R5: slot %0d changed without a write", s);
        end
    endgenerate

    assign rd_data = regs_q[slot];
endmodule

// File: rtl/led_ctrl_i2c_target.sv
// Top level. It synchronises the hardware reset pin and the two bus lines,
// turns the edges into START and STOP, and connects the protocol engine to
// the register file. Assumes SCL and SDA are glitch-free and slow compared
// with clk (several clk cycles per bus phase).
module led_ctrl_i2c_target
    import led_i2c_pkg::*;
#(
    parameter int         SYNC_STAGES = 2,
    parameter logic [6:0] ADDR_LO     = 7'h36,
    parameter logic [6:0] ADDR_HI     = 7'h38
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       hw_rst_n,
    input  logic       addr_sel,
    input  logic       scl_i,
    input  logic       sda_i,
    output logic       sda_oe,
    output logic [7:0] gp_ctrl,
    output logic [7:0] bank_a_lvl,
    output logic [7:0] bank_b_lvl,
    output logic [7:0] bank_c_lvl
);
    localparam int SCL_B = 0;
    localparam int SDA_B = 1;

    logic [SYNC_STAGES-1:0]         hw_pipe;
    logic                           rst_ok;
    logic [1:0]                     lvl, rise, fall;
    logic                           bus_start, bus_stop;
    logic [SLOT_W-1:0]              slot_ptr;
    logic                           wr_en;
    logic [BYTE_W-1:0]              wr_data, rd_data;
    logic [NUM_REGS-1:0][BYTE_W-1:0] regs_q;

    // Synchronise the hardware reset pin into the clk domain.
    always_ff @(posedge clk) begin
        if (!rst_n) hw_pipe <= '0;
        else        hw_pipe <= {hw_pipe[SYNC_STAGES-2:0], hw_rst_n};
    end

    assign rst_ok = rst_n & hw_pipe[SYNC_STAGES-1];

    i2c_line_sync #(.W(2), .STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  ({sda_i, scl_i}),
        .lvl  (lvl),
        .rise (rise),
        .fall (fall)
    );

    assign bus_start = fall[SDA_B] & lvl[SCL_B];
    assign bus_stop  = rise[SDA_B] & lvl[SCL_B];

    i2c_byte_engine #(.ADDR_LO(ADDR_LO), .ADDR_HI(ADDR_HI)) u_engine (
        .clk      (clk),
        .rst_ok   (rst_ok),
        .addr_sel (addr_sel),
        .scl_lvl  (lvl[SCL_B]),
        .sda_lvl  (lvl[SDA_B]),
        .scl_rise (rise[SCL_B]),
        .scl_fall (fall[SCL_B]),
        .bus_start(bus_start),
        .bus_stop (bus_stop),
        .rd_data  (rd_data),
        .slot_ptr (slot_ptr),
        .wr_en    (wr_en),
        .wr_data  (wr_data),
        .sda_oe   (sda_oe)
    );

    led_reg_file u_regs (
        .clk    (clk),
        .rst_ok (rst_ok),
        .wr_en  (wr_en),
        .slot   (slot_ptr),
        .wr_data(wr_data),
        .regs_q (regs_q),
        .rd_data(rd_data)
    );

    assign gp_ctrl    = regs_q[0];
    assign bank_a_lvl = regs_q[1];
    assign bank_b_lvl = regs_q[2];
    assign bank_c_lvl = regs_q[3];

    assert_pin_reset_release_R11: assert property (@(posedge clk)
        !rst_ok |=> !sda_oe)
        else $error("R11: SDA driven after reset");
endmodule

// File: tb/tb_led_ctrl_i2c_target.sv
`timescale 1ns/1ps
module tb_led_ctrl_i2c_target;
    localparam int Q = 10;

    typedef struct {
        logic [8:0] val;
        string      req;
    } frame_t;

    logic clk = 1'b0;
    logic rst_n, hw_rst_n, addr_sel, scl_m, sda_m;
    logic sda_oe, sda_line;
    logic [7:0] gp_ctrl, bank_a_lvl, bank_b_lvl, bank_c_lvl;
    int checks = 0, errors = 0;
    bit done = 1'b0;
    frame_t exp_q[$];

    always #5 clk = ~clk;

    assign sda_line = sda_m & ~sda_oe;

    led_ctrl_i2c_target dut (
        .clk(clk), .rst_n(rst_n), .hw_rst_n(hw_rst_n), .addr_sel(addr_sel),
        .scl_i(scl_m), .sda_i(sda_line), .sda_oe(sda_oe),
        .gp_ctrl(gp_ctrl), .bank_a_lvl(bank_a_lvl),
        .bank_b_lvl(bank_b_lvl), .bank_c_lvl(bank_c_lvl)
    );

    // Monitor: frames of 9 bits between START and STOP, compared with the queue.
    logic       mon_act = 1'b0;
    int         mon_cnt = 0;
    logic [8:0] mon_sh  = '0;
    always @(negedge sda_line) if (scl_m === 1'b1) begin mon_act = 1'b1; mon_cnt = 0; end
    always @(posedge sda_line) if (scl_m === 1'b1) mon_act = 1'b0;
    always @(posedge scl_m) if (mon_act) begin
        mon_sh = {mon_sh[7:0], sda_line};
        mon_cnt++;
        if (mon_cnt == 9) begin
            frame_t f;
            mon_cnt = 0;
            checks++;
            if (exp_q.size() == 0) begin
                errors++;
                $display("FAIL unexpected frame got %h exp none", mon_sh);
            end else begin
                f = exp_q.pop_front();
                if (mon_sh !== f.val) begin
                    errors++;
                    $display("FAIL %s frame got %h exp %h", f.req, mon_sh, f.val);
                end
            end
        end
    end

    task automatic wait_q(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check8(input logic [7:0] act, input logic [7:0] exp, input string req);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s got %h exp %h", req, act, exp);
        end
    endtask

    task automatic bus_bit(input logic v);
        sda_m = v; wait_q(Q);
        scl_m = 1'b1; wait_q(2*Q);
        scl_m = 1'b0; wait_q(Q);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; wait_q(Q);
        scl_m = 1'b1; wait_q(Q);
        sda_m = 1'b0; wait_q(Q);
        scl_m = 1'b0; wait_q(Q);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; wait_q(Q);
        scl_m = 1'b1; wait_q(Q);
        sda_m = 1'b1; wait_q(Q);
    endtask

    task automatic raw_byte(input logic [7:0] b);
        for (int i = 7; i >= 0; i--) bus_bit(b[i]);
        bus_bit(1'b1);
    endtask

    // Driver: push the expected frame, then clock a byte out (acknowledge slot released).
    task automatic send_byte(input logic [7:0] b, input bit ack, input string req);
        frame_t f;
        f.val = {b, ~ack};
        f.req = req;
        exp_q.push_back(f);
        raw_byte(b);
    endtask

    // Driver: push the expected read frame, then clock it in with the controller's ack bit.
    task automatic recv_byte(input logic [7:0] expv, input bit mack, input string req);
        frame_t f;
        f.val = {expv, ~mack};
        f.req = req;
        exp_q.push_back(f);
        for (int i = 0; i < 8; i++) bus_bit(1'b1);
        bus_bit(~mack);
    endtask

    task automatic check_all(input logic [7:0] g, a, b, c, input string req);
        check8(gp_ctrl, g, req);
        check8(bank_a_lvl, a, req);
        check8(bank_b_lvl, b, req);
        check8(bank_c_lvl, c, req);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired got hang exp completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; hw_rst_n = 1'b1; addr_sel = 1'b0; scl_m = 1'b1; sda_m = 1'b1;
        wait_q(6);
        rst_n = 1'b1;
        wait_q(6);
        // R1 reset state
        check_all(8'h20, 8'hE0, 8'hE0, 8'hFC, "R1");
        check8({7'd0, sda_oe}, 8'd0, "R1 sda_oe");

        // R2 R4 R6: write bank A with strap low
        bus_start(); send_byte(8'h6C, 1, "R2"); send_byte(8'hA0, 1, "R4"); send_byte(8'h15, 1, "R4");
        bus_stop(); wait_q(Q);
        check8(bank_a_lvl, 8'hF5, "R4 R6 bank A");

        // R4 general control, all bits writable
        bus_start(); send_byte(8'h6C, 1, "R2"); send_byte(8'h10, 1, "R4"); send_byte(8'h5A, 1, "R4");
        bus_stop(); wait_q(Q);
        check8(gp_ctrl, 8'h5A, "R4 gp");

        // R6 masks on banks C and B
        bus_start(); send_byte(8'h6C, 1, "R2"); send_byte(8'hC0, 1, "R4"); send_byte(8'h01, 1, "R6");
        bus_stop(); wait_q(Q);
        check8(bank_c_lvl, 8'hFD, "R6 bank C");
        bus_start(); send_byte(8'h6C, 1, "R2"); send_byte(8'hB0, 1, "R4"); send_byte(8'h00, 1, "R6");
        bus_stop(); wait_q(Q);
        check8(bank_b_lvl, 8'hE0, "R6 bank B zero");
        bus_start(); send_byte(8'h6C, 1, "R2"); send_byte(8'hB0, 1, "R4"); send_byte(8'hFF, 1, "R6");
        bus_stop(); wait_q(Q);
        check8(bank_b_lvl, 8'hFF, "R6 bank B ones");

        // R3 wrong address with strap low
        bus_start(); send_byte(8'h70, 0, "R3"); send_byte(8'hA0, 0, "R3"); send_byte(8'h00, 0, "R3");
        bus_stop(); wait_q(Q);
        check_all(8'h5A, 8'hF5, 8'hFF, 8'hFD, "R3");

        // R2 strap high selects 7'h38; old address now rejected (R3)
        addr_sel = 1'b1; wait_q(Q);
        bus_start(); send_byte(8'h70, 1, "R2"); send_byte(8'hA0, 1, "R4"); send_byte(8'h0A, 1, "R4");
        bus_stop(); wait_q(Q);
        check8(bank_a_lvl, 8'hEA, "R2 strap high");
        bus_start(); send_byte(8'h6C, 0, "R3"); send_byte(8'hA0, 0, "R3"); send_byte(8'h1F, 0, "R3");
        bus_stop(); wait_q(Q);
        check8(bank_a_lvl, 8'hEA, "R3 strap high");

        // R5 invalid index
        bus_start(); send_byte(8'h70, 1, "R2"); send_byte(8'h20, 0, "R5"); send_byte(8'h11, 0, "R5");
        bus_stop(); wait_q(Q);
        check_all(8'h5A, 8'hEA, 8'hFF, 8'hFD, "R5");

        // R7 second data byte refused
        bus_start(); send_byte(8'h70, 1, "R2"); send_byte(8'hC0, 1, "R4"); send_byte(8'h02, 1, "R4");
        send_byte(8'h03, 0, "R7");
        bus_stop(); wait_q(Q);
        check8(bank_c_lvl, 8'hFE, "R7");

        // R8 repeated START right after an index ack
        bus_start(); send_byte(8'h70, 1, "R2"); send_byte(8'hA0, 1, "R4");
        bus_start(); send_byte(8'h70, 1, "R8"); send_byte(8'hB0, 1, "R8"); send_byte(8'h07, 1, "R8");
        bus_stop(); wait_q(Q);
        check8(bank_a_lvl, 8'hEA, "R8 bank A untouched");
        check8(bank_b_lvl, 8'hE7, "R8 bank B");

        // R9 bytes after STOP without START
        bus_start(); send_byte(8'h70, 1, "R2"); send_byte(8'h10, 1, "R4");
        bus_stop(); wait_q(Q);
        scl_m = 1'b0; wait_q(Q);
        raw_byte(8'h00); raw_byte(8'h70); raw_byte(8'h10); raw_byte(8'h00);
        bus_stop(); wait_q(Q);
        check8(gp_ctrl, 8'h5A, "R9");

        // R10 read of bank B after an index write, ACK then NACK
        bus_start(); send_byte(8'h70, 1, "R2"); send_byte(8'hB0, 1, "R10");
        bus_start(); send_byte(8'h71, 1, "R10");
        recv_byte(8'hE7, 1, "R10 first"); recv_byte(8'hE7, 0, "R10 repeat");
        bus_stop(); wait_q(Q);
        check8({7'd0, sda_oe}, 8'd0, "R10 released");

        // R11 hardware reset pin, with a write attempted while low
        hw_rst_n = 1'b0; wait_q(6);
        check_all(8'h20, 8'hE0, 8'hE0, 8'hFC, "R11 pin low");
        bus_start(); send_byte(8'h70, 0, "R11"); send_byte(8'hA0, 0, "R11"); send_byte(8'h1F, 0, "R11");
        bus_stop(); wait_q(Q);
        hw_rst_n = 1'b1; wait_q(6);
        check_all(8'h20, 8'hE0, 8'hE0, 8'hFC, "R11 after release");

        wait_q(Q);
        checks++;
        if (exp_q.size() != 0) begin
            errors++;
            $display("FAIL scoreboard got %0d pending exp 0", exp_q.size());
        end
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule